// File: doc/BRIEF.md
# Memory Power-Mode Sequencer

This block sits between a power-management requester and one embedded memory macro. The requester asks for one of four power states: full operation, light sleep, deep sleep or full power-off. The block then drives the macro's light-sleep, deep-sleep, power-off and isolation pins one step at a time. A pin changes only on a clock edge, and never two in a way that breaks the required order. A separate output asks the supply network to drop the bit-cell array to a retention voltage. That request is made only in the states where the array keeps its contents and no access can happen, and only when the macro is built with separate array and periphery supplies.

Supply switching and voltage settling happen outside the block. A settle count, given on an input, stands in for them. The block waits that many cycles after each voltage or power change before the next step. Before it enters any low-power state, it stalls new memory accesses and waits until the access in flight has drained. It reports a busy flag while a sequence runs and a one-cycle acknowledge once the target state is fully reached. When the macro leaves power-off, a sticky flag reports that its contents are gone. The flag stays set until the requester clears it.

Top module: `mempwr_seq`

## Requirements
- R1: After synchronous reset, every macro pin and the retention-rail request are low, the reported mode is normal, and `req_busy`, `req_ack`, `acc_stall` and `data_lost` are low.
- R2: `req_mode` encodes 0 = normal, 1 = light sleep, 2 = deep sleep, 3 = power-off. A request is taken only while `req_busy` is low, and `req_busy` is high in the cycle after it is taken. A request made while `req_busy` is high is ignored.
- R3: `req_ack` is high for exactly one cycle. In that cycle `req_busy` is low and `cur_mode` first shows the requested mode. A request for the mode already held is acknowledged within three cycles.
- R4: On deep-sleep entry, isolation rises in an earlier cycle than the deep-sleep pin. On exit, the deep-sleep pin falls in an earlier cycle than isolation. The deep-sleep pin is never high while isolation is low.
- R5: The retention-rail request is high only while light or deep sleep is held and power-off is low. On entry it rises after the sleep pin.
- R6: With `split_rail` low, the retention-rail request never rises, and the sleep states are entered without it.
- R7: On leaving light or deep sleep with the retention rail requested, the request is released first. The sleep pin falls at least `settle_cnt` cycles later.
- R8: While `acc_pending` is high, no light-sleep, deep-sleep or power-off pin rises. The sequence waits with `req_busy` high.
- R9: `acc_stall` is high whenever a sequence runs or any sleep or power-off pin is high. It is low when the block rests in normal mode.
- R10: Leaving power-off sets `data_lost` in the same cycle the power-off pin falls. The flag holds until `data_lost_clr` is high on a clock edge. The acknowledge follows the power-off release by at least `settle_cnt` cycles.
- R11: At most one of the light-sleep, deep-sleep and power-off pins is high at any time. A change between two low-power modes passes through the fully woken state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory macro |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Power-state request strobe |
| req_mode | input | 2 | Requested state (0 normal, 1 light, 2 deep, 3 off) |
| split_rail | input | 1 | High when array and periphery have separate supplies |
| settle_cnt | input | CNT_W | Cycles to wait after a voltage or power change |
| acc_pending | input | 1 | A memory access is in flight |
| data_lost_clr | input | 1 | Clears the data-lost flag |
| req_busy | output | 1 | Sequence in progress |
| req_ack | output | 1 | One-cycle pulse when the target state is reached |
| cur_mode | output | 2 | Last acknowledged state |
| acc_stall | output | 1 | Blocks new memory accesses |
| mem_ls | output | 1 | Macro light-sleep pin |
| mem_ds | output | 1 | Macro deep-sleep pin |
| mem_sd | output | 1 | Macro power-off pin |
| mem_iso | output | 1 | Macro input isolation pin |
| rail_low | output | 1 | Request for the low retention voltage on the array |
| data_lost | output | 1 | Contents lost after power-off |

## Verification
The bound checker tests several rules on every cycle. It checks that deep sleep is always covered by isolation and that the retention request appears only with a retaining sleep mode. It checks that the sleep pins are mutually exclusive and that the retention request never rises on a single-rail macro. It also checks that the acknowledge is a lone pulse and that the data-lost flag rises only as power-off is released. A counter in the checker measures the settle window from rail release to sleep-pin release. Other behaviour shows only in the bench's scenarios: requests ignored while busy, the drain wait on an in-flight access, the flag holding until cleared, and the returned mode after chained transitions.

// File: rtl/mempwr_pkg.sv
package mempwr_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_LIGHT  = 2'd1,
        PM_DEEP   = 2'd2,
        PM_OFF    = 2'd3
    } pm_mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_EXIT_POWER,
        SQ_EXIT_WAIT,
        SQ_EXIT_PINS,
        SQ_EXIT_ISO,
        SQ_DRAIN,
        SQ_ENT_ISO,
        SQ_ENT_PIN,
        SQ_ENT_RAIL,
        SQ_ENT_WAIT,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic light;
        logic deep;
        logic off;
        logic iso;
        logic rail_low;
    } macro_pins_t;

    localparam macro_pins_t PINS_AWAKE = '0;

    // Modes where the array holds data and is never accessed
    function automatic logic mode_retains_idle(pm_mode_e m);
        return (m == PM_LIGHT) || (m == PM_DEEP);
    endfunction

    function automatic logic mode_needs_iso(pm_mode_e m);
        return m == PM_DEEP;
    endfunction

    // Step after the sleep pins have been cleared on the way out
    function automatic seq_state_e after_wake(pm_mode_e tgt, logic iso_on);
        if (iso_on)
            return SQ_EXIT_ISO;
        else if (tgt == PM_NORMAL)
            return SQ_DONE;
        else
            return SQ_DRAIN;
    endfunction

endpackage

// File: rtl/mempwr_settle_timer.sv
module mempwr_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0) && !load;

endmodule

// File: rtl/mempwr_seq_fsm.sv
module mempwr_seq_fsm
    import mempwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_mode,
    input  logic        split_rail,
    input  logic        acc_pending,
    input  logic        tmr_expired,
    output logic        tmr_load,
    output macro_pins_t pins,
    output pm_mode_e    mode,
    output logic        busy,
    output logic        ack,
    output logic        left_off
);
    seq_state_e  state_q;
    pm_mode_e    tgt_q;
    pm_mode_e    mode_q;
    macro_pins_t pins_q;
    logic        ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tgt_q   <= PM_NORMAL;
            mode_q  <= PM_NORMAL;
            pins_q  <= PINS_AWAKE;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (req_valid) begin
                        tgt_q <= pm_mode_e'(req_mode);
                        if (pm_mode_e'(req_mode) == mode_q)
                            state_q <= SQ_DONE;
                        else if (mode_q == PM_NORMAL)
                            state_q <= SQ_DRAIN;
                        else
                            state_q <= SQ_EXIT_POWER;
                    end
                end
                SQ_EXIT_POWER: begin
                    if (pins_q.off) begin
                        pins_q.off <= 1'b0;
                        state_q    <= SQ_EXIT_WAIT;
                    end else if (pins_q.rail_low) begin
                        pins_q.rail_low <= 1'b0;
                        state_q         <= SQ_EXIT_WAIT;
                    end else begin
                        state_q <= SQ_EXIT_PINS;
                    end
                end
                SQ_EXIT_WAIT: begin
                    if (tmr_expired)
                        state_q <= SQ_EXIT_PINS;
                end
                SQ_EXIT_PINS: begin
                    pins_q.light <= 1'b0;
                    pins_q.deep  <= 1'b0;
                    state_q      <= after_wake(tgt_q, pins_q.iso);
                end
                SQ_EXIT_ISO: begin
                    pins_q.iso <= 1'b0;
                    state_q    <= (tgt_q == PM_NORMAL) ? SQ_DONE : SQ_DRAIN;
                end
                SQ_DRAIN: begin
                    if (!acc_pending)
                        state_q <= mode_needs_iso(tgt_q) ? SQ_ENT_ISO : SQ_ENT_PIN;
                end
                SQ_ENT_ISO: begin
                    pins_q.iso <= 1'b1;
                    state_q    <= SQ_ENT_PIN;
                end
                SQ_ENT_PIN: begin
                    pins_q.light <= (tgt_q == PM_LIGHT);
                    pins_q.deep  <= (tgt_q == PM_DEEP);
                    pins_q.off   <= (tgt_q == PM_OFF);
                    if (mode_retains_idle(tgt_q) && split_rail)
                        state_q <= SQ_ENT_RAIL;
                    else
                        state_q <= SQ_DONE;
                end
                SQ_ENT_RAIL: begin
                    pins_q.rail_low <= 1'b1;
                    state_q         <= SQ_ENT_WAIT;
                end
                SQ_ENT_WAIT: begin
                    if (tmr_expired)
                        state_q <= SQ_DONE;
                end
                SQ_DONE: begin
                    ack_q   <= 1'b1;
                    mode_q  <= tgt_q;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign tmr_load = ((state_q == SQ_EXIT_POWER) && (pins_q.off || pins_q.rail_low))
                    || (state_q == SQ_ENT_RAIL);
    assign left_off = (state_q == SQ_EXIT_POWER) && pins_q.off;
    assign pins     = pins_q;
    assign mode     = mode_q;
    assign busy     = (state_q != SQ_IDLE);
    assign ack      = ack_q;

endmodule

// File: rtl/mempwr_status.sv
module mempwr_status
    import mempwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        left_off,
    input  logic        lost_clr,
    input  logic        busy,
    input  macro_pins_t pins,
    output logic        data_lost,
    output logic        acc_stall
);
    logic lost_q;

    // Setting wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            lost_q <= 1'b0;
        else if (left_off)
            lost_q <= 1'b1;
        else if (lost_clr)
            lost_q <= 1'b0;
    end

    assign data_lost = lost_q;
    assign acc_stall = busy || pins.light || pins.deep || pins.off;

endmodule

// File: rtl/mempwr_seq.sv
module mempwr_seq
    import mempwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic             split_rail,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic             acc_pending,
    input  logic             data_lost_clr,
    output logic             req_busy,
    output logic             req_ack,
    output logic [1:0]       cur_mode,
    output logic             acc_stall,
    output logic             mem_ls,
    output logic             mem_ds,
    output logic             mem_sd,
    output logic             mem_iso,
    output logic             rail_low,
    output logic             data_lost
);
    logic        tmr_load;
    logic        tmr_expired;
    logic        left_off;
    macro_pins_t pins;
    pm_mode_e    mode;

    mempwr_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (settle_cnt),
        .expired  (tmr_expired)
    );

    mempwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .split_rail  (split_rail),
        .acc_pending (acc_pending),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .pins        (pins),
        .mode        (mode),
        .busy        (req_busy),
        .ack         (req_ack),
        .left_off    (left_off)
    );

    mempwr_status u_status (
        .clk       (clk),
        .rst       (rst),
        .left_off  (left_off),
        .lost_clr  (data_lost_clr),
        .busy      (req_busy),
        .pins      (pins),
        .data_lost (data_lost),
        .acc_stall (acc_stall)
    );

    assign cur_mode = mode;
    assign mem_ls   = pins.light;
    assign mem_ds   = pins.deep;
    assign mem_sd   = pins.off;
    assign mem_iso  = pins.iso;
    assign rail_low = pins.rail_low;

endmodule

// File: rtl/mempwr_seq_chk.sv
module mempwr_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             split_rail,
    input logic [CNT_W-1:0] settle_cnt,
    input logic             req_busy,
    input logic             req_ack,
    input logic             mem_ls,
    input logic             mem_ds,
    input logic             mem_sd,
    input logic             mem_iso,
    input logic             rail_low,
    input logic             data_lost
);
    localparam int SW = CNT_W + 1;

    logic          rail_q, ls_q, ds_q, armed_q;
    logic [SW-1:0] since_q;
    logic          sleep_fell;

    assign sleep_fell = (ls_q && !mem_ls) || (ds_q && !mem_ds);

    // Cycles since the retention request was last released
    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q  <= 1'b0;
            ls_q    <= 1'b0;
            ds_q    <= 1'b0;
            armed_q <= 1'b0;
            since_q <= '0;
        end else begin
            rail_q <= rail_low;
            ls_q   <= mem_ls;
            ds_q   <= mem_ds;
            if (rail_q && !rail_low) begin
                since_q <= '0;
                armed_q <= 1'b1;
            end else begin
                if (since_q != {SW{1'b1}})
                    since_q <= since_q + 1'b1;
                if (sleep_fell)
                    armed_q <= 1'b0;
            end
        end
    end

    assert_settle_window_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && sleep_fell) |-> (since_q >= SW'(settle_cnt)));

    assert_iso_covers_ds_R4: assert property (@(posedge clk) disable iff (rst)
        mem_ds |-> mem_iso);

    assert_iso_before_ds_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ds) |-> $past(mem_iso));

    assert_rail_modes_R5: assert property (@(posedge clk) disable iff (rst)
        rail_low |-> ((mem_ls || mem_ds) && !mem_sd));

    assert_rail_split_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_low) |-> split_rail);

    assert_one_mode_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_ls, mem_ds, mem_sd}));

    assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_ack_idle_R3: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !req_busy);

    assert_lost_origin_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(data_lost) |-> $fell(mem_sd));

endmodule

bind mempwr_seq mempwr_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .split_rail (split_rail),
    .settle_cnt (settle_cnt),
    .req_busy   (req_busy),
    .req_ack    (req_ack),
    .mem_ls     (mem_ls),
    .mem_ds     (mem_ds),
    .mem_sd     (mem_sd),
    .mem_iso    (mem_iso),
    .rail_low   (rail_low),
    .data_lost  (data_lost)
);

// File: tb/mempwr_seq_test.sv
`timescale 1ns/1ps
module mempwr_seq_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic          split_rail = 1'b1;
    logic [CW-1:0] settle_cnt = 8'd4;
    logic          acc_pending = 1'b0;
    logic          data_lost_clr = 1'b0;
    logic          req_busy, req_ack, acc_stall;
    logic [1:0]    cur_mode;
    logic          mem_ls, mem_ds, mem_sd, mem_iso, rail_low, data_lost;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // event log, sampled at the falling edge
    int ev_ls_rise, ev_ls_fall, ev_ds_rise, ev_ds_fall, ev_iso_rise, ev_iso_fall;
    int ev_rail_rise, ev_rail_fall, ev_sd_fall, ev_ack;
    int v_iso = 0, v_rail = 0, v_split = 0, v_drain = 0, v_multi = 0;
    logic p_ls = 0, p_ds = 0, p_sd = 0, p_iso = 0, p_rail = 0, p_pend = 0;

    mempwr_seq #(.CNT_W(CW)) uut (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ls && !p_ls) ev_ls_rise = cyc;
            if (!mem_ls && p_ls) ev_ls_fall = cyc;
            if (mem_ds && !p_ds) ev_ds_rise = cyc;
            if (!mem_ds && p_ds) ev_ds_fall = cyc;
            if (mem_iso && !p_iso) ev_iso_rise = cyc;
            if (!mem_iso && p_iso) ev_iso_fall = cyc;
            if (rail_low && !p_rail) ev_rail_rise = cyc;
            if (!rail_low && p_rail) ev_rail_fall = cyc;
            if (!mem_sd && p_sd) ev_sd_fall = cyc;
            if (req_ack) ev_ack = cyc;
            if (mem_ds && !mem_iso) v_iso++;
            if (rail_low && (mem_sd || !(mem_ls || mem_ds))) v_rail++;
            if (rail_low && !p_rail && !split_rail) v_split++;
            if (p_pend && ((mem_ls && !p_ls) || (mem_ds && !p_ds) || (mem_sd && !p_sd))) v_drain++;
            if (int'(mem_ls) + int'(mem_ds) + int'(mem_sd) > 1) v_multi++;
        end
        p_ls = mem_ls; p_ds = mem_ds; p_sd = mem_sd; p_iso = mem_iso;
        p_rail = rail_low; p_pend = acc_pending;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1;
        req_mode  = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ack(input string tag);
        bit got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (i > 0) @(negedge clk);
            if (req_ack) got = 1'b1;
        end
        check(got, {tag, " ack arrives"}, got, 1);
    endtask

    task automatic go(input logic [1:0] m, input string tag);
        send(m);
        wait_ack(tag);
        check(cur_mode == m && !req_busy, {tag, " R3 mode shown with ack"}, cur_mode, m);
        @(negedge clk);
        check(!req_ack, {tag, " R3 ack single cycle"}, req_ack, 0);
    endtask

    task automatic t_reset;
        check({mem_ls, mem_ds, mem_sd, mem_iso, rail_low} == 5'b0, "R1 pins low", mem_ls, 0);
        check(cur_mode == 2'd0, "R1 mode normal", cur_mode, 0);
        check(!req_busy && !req_ack && !acc_stall && !data_lost, "R1 flags low",
              {req_busy, req_ack, acc_stall, data_lost}, 0);
    endtask

    task automatic t_light;
        settle_cnt = 8'd6;
        split_rail = 1'b1;
        send(2'd1);
        check(req_busy, "R2 busy after accept", req_busy, 1);
        check(acc_stall, "R9 stall while busy", acc_stall, 1);
        wait_ack("light entry");
        check(mem_ls && rail_low && !mem_ds && !mem_sd, "R5 light with retention",
              {mem_ls, mem_ds, mem_sd, rail_low}, 4'b1001);
        check(ev_rail_rise > ev_ls_rise, "R5 rail after sleep pin", ev_rail_rise, ev_ls_rise + 1);
        check(acc_stall, "R9 stall in light sleep", acc_stall, 1);
        go(2'd0, "light exit");
        check(ev_ls_fall - ev_rail_fall >= 6, "R7 light settle", ev_ls_fall - ev_rail_fall, 6);
        check(!mem_ls && !rail_low && !acc_stall, "R9 awake no stall", acc_stall, 0);
    endtask

    task automatic t_deep;
        settle_cnt = 8'd9;
        go(2'd2, "deep entry");
        check(mem_ds && mem_iso && rail_low, "R4 deep held", {mem_ds, mem_iso, rail_low}, 7);
        check(ev_iso_rise < ev_ds_rise, "R4 iso before ds", ev_iso_rise, ev_ds_rise - 1);
        check(ev_rail_rise > ev_ds_rise, "R5 rail after ds", ev_rail_rise, ev_ds_rise + 1);
        go(2'd0, "deep exit");
        check(ev_ds_fall - ev_rail_fall >= 9, "R7 deep settle", ev_ds_fall - ev_rail_fall, 9);
        check(ev_iso_fall > ev_ds_fall, "R4 ds before iso release", ev_iso_fall, ev_ds_fall + 1);
        check({mem_ds, mem_iso, rail_low} == 3'b0, "R4 fully awake", {mem_ds, mem_iso, rail_low}, 0);
    endtask

    task automatic t_single_rail;
        split_rail = 1'b0;
        settle_cnt = 8'd3;
        go(2'd2, "single deep");
        check(mem_ds && !rail_low, "R6 no retention single rail", rail_low, 0);
        go(2'd1, "single light");
        check(mem_ls && !rail_low, "R6 light no retention", rail_low, 0);
        go(2'd0, "single exit");
        split_rail = 1'b1;
    endtask

    task automatic t_drain;
        int early = 0;
        settle_cnt = 8'd2;
        acc_pending = 1'b1;
        send(2'd1);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (mem_ls || mem_ds || mem_sd || !req_busy) early++;
        end
        check(early == 0, "R8 hold while access pending", early, 0);
        acc_pending = 1'b0;
        wait_ack("drain");
        check(mem_ls, "R8 entry after drain", mem_ls, 1);
        go(2'd0, "drain exit");
    endtask

    task automatic t_busy_ignore;
        int stray = 0;
        settle_cnt = 8'd20;
        send(2'd1);
        req_valid = 1'b1;
        req_mode  = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        wait_ack("ignore");
        check(cur_mode == 2'd1 && !mem_ds, "R2 busy request ignored", cur_mode, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_busy || req_ack) stray++;
        end
        check(stray == 0, "R2 no late sequence", stray, 0);
        go(2'd0, "ignore exit");
    endtask

    task automatic t_same_mode;
        int waited = 0;
        send(2'd0);
        while (!req_ack && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        check(req_ack && waited <= 2, "R3 same mode quick ack", waited, 2);
    endtask

    task automatic t_shutdown;
        settle_cnt = 8'd5;
        go(2'd3, "off entry");
        check(mem_sd && !rail_low && !mem_iso && !data_lost, "R5 off without retention",
              {mem_sd, rail_low, mem_iso, data_lost}, 8);
        go(2'd0, "off exit");
        check(!mem_sd && data_lost, "R10 lost flag set", data_lost, 1);
        check(ev_ack - ev_sd_fall >= 5, "R10 power-up settle", ev_ack - ev_sd_fall, 5);
        repeat (3) @(negedge clk);
        check(data_lost, "R10 flag holds", data_lost, 1);
        data_lost_clr = 1'b1;
        @(negedge clk);
        data_lost_clr = 1'b0;
        check(!data_lost, "R10 flag cleared", data_lost, 0);
    endtask

    task automatic t_chain;
        settle_cnt = 8'd3;
        go(2'd1, "chain light");
        go(2'd2, "chain deep");
        check(mem_ds && !mem_ls, "R11 light to deep", {mem_ls, mem_ds}, 1);
        check(ev_ls_fall < ev_iso_rise, "R11 wake between modes", ev_ls_fall, ev_iso_rise - 1);
        go(2'd3, "chain off");
        check(mem_sd && !mem_ds && !mem_iso, "R11 deep to off", {mem_sd, mem_ds, mem_iso}, 4);
        go(2'd0, "chain wake");
        data_lost_clr = 1'b1;
        @(negedge clk);
        data_lost_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_light();
        t_deep();
        t_single_rail();
        t_drain();
        t_busy_ignore();
        t_same_mode();
        t_shutdown();
        t_chain();
        check(v_iso == 0, "R4 ds never without iso", v_iso, 0);
        check(v_rail == 0, "R5 retention only in sleep", v_rail, 0);
        check(v_split == 0, "R6 no retention rise single rail", v_split, 0);
        check(v_drain == 0, "R8 no entry while pending", v_drain, 0);
        check(v_multi == 0, "R11 modes exclusive", v_multi, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule